// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block is the digital back end of a flash analog-to-digital converter. It receives the outputs of a bank of 2^N−1 parallel comparators and one extra comparator that sits above full scale. Comparator k goes high when the analog input is above threshold k. A clean reading is therefore a thermometer word: a run of ones from bit 0 up to the input level, with zeros above it. The block turns that word into an N-bit binary code and a separate over-range flag.

Comparators that are close to metastable can leave a single wrong bit in the thermometer word, called a bubble. Before encoding, every bit is replaced by the majority of itself and its two neighbours. This removes an isolated zero inside the run of ones and an isolated one above it. The block then finds the single position where a one has a zero above it and encodes that position to binary.

The comparator word and the over-range bit are registered when they enter the block. The code and the flag are registered again at the output, so a sample appears at the output two clock edges after it is captured. While the over-range comparator is high, the code is forced to all ones and the flag is set. The block has no state machine: two register stages with combinational decode between them.

Top module: `flash_therm_encoder`

## Requirements
- R1: While `rst_n` is low, `code_o` is 0 and `ovr_flag_o` is 0. Reset is asynchronous.
- R2: A clean thermometer word with bits 0 to L−1 set and all higher bits clear produces `code_o` = L, for every L from 0 to 2^N−1.
- R3: A single cleared bit whose two neighbours are both set is corrected, so the code is the same as for the clean word. Only bits with a real neighbour on both sides are covered.
- R4: A single set bit whose two neighbours are both clear is discarded, so the code is the same as for the clean word without it. Only bits with a real neighbour on both sides are covered.
- R5: When `ovr_i` is high, `code_o` is all ones and `ovr_flag_o` is 1, whatever the comparator word is.
- R6: When `ovr_i` is low, `ovr_flag_o` is 0 and the code follows the comparator word.
- R7: A sample driven before clock edge E appears on both outputs just after edge E+1. The outputs do not change at edge E itself.
- R8: An all-zero comparator word with `ovr_i` low produces `code_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| comp_i | input | 2^N−1 | Comparator thermometer word; bit k is high when the input is above threshold k |
| ovr_i | input | 1 | Comparator that sits above full scale |
| code_o | output | N | Registered binary code |
| ovr_flag_o | output | 1 | Registered over-range flag |

## Verification
The only state in the block is its two register stages, so a wrong internal value cannot persist. A corrupted input-register bit, a broken majority cell or a wrong encoder mask shows up on `code_o` exactly two edges after the sample that exposes it. It is flushed by the next clean sample. A fault in the over-range path shows up as a flag that is not all ones in the code, or as a flag that arrives one edge early or late. The stimulus therefore walks every clean level, places bubbles in the interior, and checks the output one edge before the sample arrives and on the edge it arrives.

// File: rtl/tenc_pkg.sv
package tenc_pkg;

    // Majority of three neighbouring comparator bits.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Number of comparators for an N-bit flash converter.
    function automatic int comp_count(input int bits);
        return (1 << bits) - 1;
    endfunction

endpackage

// File: rtl/tenc_bubble_filter.sv
module tenc_bubble_filter
    import tenc_pkg::*;
#(
    parameter int WIDTH = 15
) (
    input  logic [WIDTH-1:0] therm_i,
    output logic [WIDTH-1:0] therm_o
);

    // Pad below with one (ground is always exceeded) and above with zero.
    logic [WIDTH+1:0] padded;

    assign padded = {1'b0, therm_i, 1'b1};

    for (genvar k = 0; k < WIDTH; k++) begin : g_maj
        assign therm_o[k] = maj3(padded[k], padded[k+1], padded[k+2]);
    end

endmodule

// File: rtl/tenc_edge_detect.sv
module tenc_edge_detect #(
    parameter int WIDTH = 15
) (
    input  logic [WIDTH-1:0] therm_i,
    output logic [WIDTH-1:0] hot_o
);

    // Position k is hot when comparator k is set and comparator k+1 is clear.
    logic [WIDTH:0] above;

    assign above = {1'b0, therm_i};

    for (genvar k = 0; k < WIDTH; k++) begin : g_edge
        assign hot_o[k] = above[k] & ~above[k+1];
    end

endmodule

// File: rtl/tenc_onehot_encode.sv
module tenc_onehot_encode #(
    parameter int N     = 4,
    parameter int WIDTH = 15
) (
    input  logic [WIDTH-1:0] hot_i,
    output logic [N-1:0]     code_o
);

    // Hot position k stands for level k+1; each code bit ORs the positions
    // whose level has that bit set.
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_comb begin
            code_o[b] = 1'b0;
            for (int k = 0; k < WIDTH; k++) begin
                if (((k + 1) >> b) & 1) begin
                    code_o[b] = code_o[b] | hot_i[k];
                end
            end
        end
    end

endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
    import tenc_pkg::*;
#(
    parameter  int N  = 4,
    localparam int CW = (1 << N) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] comp_i,
    input  logic          ovr_i,
    output logic [N-1:0]  code_o,
    output logic          ovr_flag_o
);

    localparam logic [N-1:0] FULL_CODE = {N{1'b1}};

    // Input capture stage.
    logic [CW-1:0] comp_q;
    logic          ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            comp_q <= comp_i;
            ovr_q  <= ovr_i;
        end
    end

    // Decode path between the two register stages.
    logic [CW-1:0] clean_w;
    logic [CW-1:0] hot_w;
    logic [N-1:0]  enc_w;

    tenc_bubble_filter #(.WIDTH(CW)) filt_i (
        .therm_i (comp_q),
        .therm_o (clean_w)
    );

    tenc_edge_detect #(.WIDTH(CW)) edge_i (
        .therm_i (clean_w),
        .hot_o   (hot_w)
    );

    tenc_onehot_encode #(.N(N), .WIDTH(CW)) enc_i (
        .hot_i  (hot_w),
        .code_o (enc_w)
    );

    // Output stage, saturating when the over-range comparator is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o     <= '0;
            ovr_flag_o <= 1'b0;
        end else begin
            code_o     <= ovr_q ? FULL_CODE : enc_w;
            ovr_flag_o <= ovr_q;
        end
    end

    // Counts edges since reset so that the latency check looks back only
    // over edges that have happened.
    logic [1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 2'd0;
        end else if (live_q != 2'd2) begin
            live_q <= live_q + 2'd1;
        end
    end

    AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag_o |-> (code_o == FULL_CODE)); // R5

    AST_FLAG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd2) |-> (ovr_flag_o == $past(ovr_i, 2))); // R7

    AST_HOT_GIVES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (|hot_w) |-> (enc_w != '0)); // R2

    AST_NO_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_w == '0) |-> (enc_w == '0)); // R8

endmodule

// File: tb/flash_therm_encoder_tb.sv
`timescale 1ns/1ps
module flash_therm_encoder_tb_top;

    localparam int N  = 4;
    localparam int CW = 15;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] comp_i = '0;
    logic          ovr_i = 1'b0;
    logic [N-1:0]  code_o;
    logic          ovr_flag_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_therm_encoder #(.N(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .comp_i     (comp_i),
        .ovr_i      (ovr_i),
        .code_o     (code_o),
        .ovr_flag_o (ovr_flag_o)
    );

    // Vector layout: [24] over-range, [23:9] comparators, [8:5] code,
    // [4] flag, [3:0] requirement number.
    function automatic logic [24:0] mk(input logic o, input logic [14:0] c,
                                       input logic [3:0] e, input logic f,
                                       input logic [3:0] r);
        return {o, c, e, f, r};
    endfunction

    localparam logic [24:0] VECS [NV] = '{
        mk(1'b0, 15'h0000, 4'd0,  1'b0, 4'd8), // R8 all zero
        mk(1'b0, 15'h0001, 4'd1,  1'b0, 4'd2), // R2 level 1
        mk(1'b0, 15'h001F, 4'd5,  1'b0, 4'd2), // R2 level 5
        mk(1'b0, 15'h00FF, 4'd8,  1'b0, 4'd2), // R2 level 8
        mk(1'b0, 15'h3FFF, 4'd14, 1'b0, 4'd2), // R2 level 14
        mk(1'b0, 15'h7FFF, 4'd15, 1'b0, 4'd2), // R2 full scale
        mk(1'b0, 15'h01F7, 4'd9,  1'b0, 4'd3), // R3 level 9, bit 3 cleared
        mk(1'b0, 15'h0FBF, 4'd12, 1'b0, 4'd3), // R3 level 12, bit 6 cleared
        mk(1'b0, 15'h0407, 4'd3,  1'b0, 4'd4), // R4 level 3, bit 10 set
        mk(1'b0, 15'h0020, 4'd0,  1'b0, 4'd4), // R4 level 0, bit 5 set
        mk(1'b1, 15'h7FFF, 4'd15, 1'b1, 4'd5), // R5 over range, full word
        mk(1'b1, 15'h0000, 4'd15, 1'b1, 4'd5), // R5 over range, empty word
        mk(1'b0, 15'h00FF, 4'd8,  1'b0, 4'd6)  // R6 over range released
    };

    function automatic string rname(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [N-1:0] ec, input logic ef);
        n_checks++;
        if (code_o !== ec || ovr_flag_o !== ef) begin
            n_errors++;
            $display("FAIL %s: code=%0d flag=%0b expected code=%0d flag=%0b",
                     req, code_o, ovr_flag_o, ec, ef);
        end
    endtask

    // Drive on a falling edge, let two rising edges pass, sample on the next falling edge.
    task automatic apply(input logic o, input logic [CW-1:0] c);
        @(negedge clk);
        comp_i = c;
        ovr_i  = o;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #50000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 4'd0, 1'b0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][24], VECS[i][23:9]);
            check(rname(int'(VECS[i][3:0])), VECS[i][8:5], VECS[i][4]);
        end

        // R2: every clean level
        for (int lv = 0; lv <= CW; lv++) begin
            apply(1'b0, CW'((1 << lv) - 1));
            check("R2", N'(lv), 1'b0);
        end

        // R7: level 3 to level 11, checked one edge early and then on time
        apply(1'b0, 15'h0007);
        check("R7", 4'd3, 1'b0);
        @(negedge clk);
        comp_i = 15'h07FF;
        @(posedge clk);
        @(negedge clk);
        check("R7", 4'd3, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R7", 4'd11, 1'b0);

        // R7: the over-range flag arrives with the same delay
        ovr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7", 4'd11, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R7", 4'd15, 1'b1);

        // R1: asynchronous reset mid-run clears both outputs at once
        #1;
        rst_n = 1'b0;
        #0.5;
        check("R1", 4'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        ovr_i = 1'b0;
        apply(1'b0, 15'h003F);
        check("R2", 4'd6, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule